// File: doc/BRIEF.md
# Main clock frequency meter

This block tells software how fast the main clock is running by comparing it against a slow reference clock. The slow-clock domain opens a gate that lasts exactly 16 slow-clock periods. The gate crosses into the main-clock domain, where an edge counter counts the main-clock cycles that fall inside it. The finished count crosses back to the slow-clock domain with a toggle handshake. There it is latched into a result register, and a ready flag is raised.

Software polls the ready flag through the read port. Once the flag is set, it reads the count in a second access. A count of zero means the main oscillator is not running, and software should fall back to the internal RC source. If the main clock is absent, the slow-clock side gives up waiting after a fixed number of slow cycles and reports zero. A one-cycle restart strobe clears the flag and starts a fresh measurement. A measurement also starts by itself after reset.

Top module: `mainclk_freq_meter`

## Requirements
- R1: While reset is held and in the first slow cycle after it is released, `ready_o` is 0 and `count_o` is 0. A status read taken at that time returns 0.
- R2: One slow cycle after reset is released, a measurement gate opens without any request. The gate stays open for exactly WIN (default 16) slow-clock periods.
- R3: The result is the number of main-clock cycles inside the gate, so it equals WIN times the clock ratio within ±1.
- R4: The main-domain counter saturates at 2^CNT_W − 1 and does not wrap. A gate longer than that reports exactly 2^CNT_W − 1.
- R5: `ready_o` rises only after the gate has closed and the count has been latched. While `ready_o` stays set, `count_o` holds its value.
- R6: If no main-clock toggle comes back within TMO (default 8) slow cycles after the gate closes, `count_o` is forced to 0 and `ready_o` is set. A later measurement with the main clock running is correct again.
- R7: A restart strobe accepted while `ready_o` is set clears `ready_o` at that slow edge and opens a new gate at the same edge. A strobe that arrives while a measurement is in progress is ignored and does not delay the result.
- R8: Read port: a read with `rd_addr_i` = 0 returns the ready flag in bit 0 and zeros above it. A read with `rd_addr_i` = 1 returns the count, zero-extended. Data appears on `rd_data_o` at the slow edge that samples `rd_en_i`, and holds while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mck_i | input | 1 | Main clock being measured |
| sclk_i | input | 1 | Slow reference clock; also clocks the register side |
| rst_i | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| start_i | input | 1 | Restart strobe, one slow cycle wide |
| rd_en_i | input | 1 | Read enable (slow domain) |
| rd_addr_i | input | 1 | Read select: 0 status, 1 count |
| count_o | output | CNT_W | Latched measurement result |
| ready_o | output | 1 | Result valid flag |
| rd_data_o | output | RD_W | Registered read data |

## Verification
If the gate length or the edge counter is wrong, the count is off by whole multiples of the clock ratio. That error shows up in the first result, about 19 slow cycles after a start. If the handshake state is wrong, `ready_o` rises too early, too late or never. If the timeout is wrong, a missing main clock leaves `ready_o` low instead of reporting zero within about 24 slow cycles. The bench checks results and ready latency against a range computed from the programmed clock ratio.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

    typedef enum logic [1:0] {
        WIN_ARM  = 2'd0,
        WIN_OPEN = 2'd1,
        WIN_WAIT = 2'd2,
        WIN_DONE = 2'd3
    } win_state_e;

    localparam logic RD_SEL_STATUS = 1'b0;
    localparam logic RD_SEL_COUNT  = 1'b1;

    typedef struct packed {
        logic       gate;
        win_state_e state;
    } win_ctl_t;

    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
        return (v >= lim) ? lim : v + 32'd1;
    endfunction

endpackage

// File: rtl/mfm_sync2.sv
module mfm_sync2 #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/mfm_edge_counter.sv
module mfm_edge_counter
    import mfm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             gate_s_i,
    output logic [CNT_W-1:0] result_o,
    output logic             tog_o
);
    localparam logic [31:0] LIMIT = (32'd1 << CNT_W) - 32'd1;

    logic             gate_d_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] res_q;
    logic             tog_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gate_d_q <= 1'b0;
            run_q    <= '0;
            res_q    <= '0;
            tog_q    <= 1'b0;
        end else begin
            gate_d_q <= gate_s_i;
            if (gate_s_i && !gate_d_q) begin
                run_q <= CNT_W'(1);
            end else if (gate_s_i) begin
                run_q <= CNT_W'(sat_inc(32'(run_q), LIMIT));
            end
            if (!gate_s_i && gate_d_q) begin
                res_q <= run_q;
                tog_q <= ~tog_q;
            end
        end
    end

    assign result_o = res_q;
    assign tog_o    = tog_q;
endmodule

// File: rtl/mfm_window_ctl.sv
module mfm_window_ctl
    import mfm_pkg::*;
#(
    parameter int WIN   = 16,
    parameter int TMO   = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             tog_s_i,
    input  logic [CNT_W-1:0] result_i,
    output logic             gate_o,
    output logic             ready_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int SPAN   = (WIN > TMO) ? WIN : TMO;
    localparam int TICK_W = $clog2(SPAN + 1);
    localparam logic [TICK_W-1:0] WIN_LAST = TICK_W'(WIN - 1);
    localparam logic [TICK_W-1:0] TMO_LAST = TICK_W'(TMO - 1);

    win_ctl_t          ctl_q, ctl_d;
    logic [TICK_W-1:0] tick_q, tick_d;
    logic              tog_seen_q;
    logic              tog_evt;
    logic              ready_q, ready_d;
    logic [CNT_W-1:0]  count_q, count_d;

    assign tog_evt = tog_s_i ^ tog_seen_q;

    always_comb begin
        ctl_d   = ctl_q;
        tick_d  = tick_q;
        ready_d = ready_q;
        count_d = count_q;
        unique case (ctl_q.state)
            WIN_ARM: begin
                ctl_d.state = WIN_OPEN;
                tick_d      = '0;
            end
            WIN_OPEN: begin
                if (tick_q == WIN_LAST) begin
                    ctl_d.state = WIN_WAIT;
                    tick_d      = '0;
                end else begin
                    tick_d = tick_q + 1'b1;
                end
            end
            WIN_WAIT: begin
                if (tog_evt) begin
                    ctl_d.state = WIN_DONE;
                    count_d     = result_i;
                    ready_d     = 1'b1;
                end else if (tick_q == TMO_LAST) begin
                    ctl_d.state = WIN_DONE;
                    count_d     = '0;
                    ready_d     = 1'b1;
                end else begin
                    tick_d = tick_q + 1'b1;
                end
            end
            WIN_DONE: begin
                if (start_i) begin
                    ctl_d.state = WIN_OPEN;
                    tick_d      = '0;
                    ready_d     = 1'b0;
                end
            end
            default: ctl_d.state = WIN_ARM;
        endcase
        ctl_d.gate = (ctl_d.state == WIN_OPEN);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q      <= '{gate: 1'b0, state: WIN_ARM};
            tick_q     <= '0;
            tog_seen_q <= 1'b0;
            ready_q    <= 1'b0;
            count_q    <= '0;
        end else begin
            ctl_q      <= ctl_d;
            tick_q     <= tick_d;
            tog_seen_q <= tog_s_i;
            ready_q    <= ready_d;
            count_q    <= count_d;
        end
    end

    assign gate_o  = ctl_q.gate;
    assign ready_o = ready_q;
    assign count_o = count_q;
endmodule

// File: rtl/mfm_read_port.sv
module mfm_read_port
    import mfm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RD_W  = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rd_en_i,
    input  logic             rd_addr_i,
    input  logic             ready_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [RD_W-1:0]  rd_data_o
);
    logic [RD_W-1:0] data_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            data_q <= '0;
        end else if (rd_en_i) begin
            if (rd_addr_i == RD_SEL_COUNT) begin
                data_q <= RD_W'(count_i);
            end else begin
                data_q <= RD_W'(ready_i);
            end
        end
    end

    assign rd_data_o = data_q;
endmodule

// File: rtl/mainclk_freq_meter.sv
module mainclk_freq_meter
    import mfm_pkg::*;
#(
    parameter int WIN   = 16,
    parameter int TMO   = 8,
    parameter int CNT_W = 16,
    parameter int RD_W  = 32
) (
    input  logic             mck_i,
    input  logic             sclk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             rd_en_i,
    input  logic             rd_addr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ready_o,
    output logic [RD_W-1:0]  rd_data_o
);
    logic             win_gate;
    logic             gate_s;
    logic [CNT_W-1:0] main_result;
    logic             main_tog;
    logic             tog_s;

    mfm_sync2 #(.W(1)) u_gate_sync (
        .clk_i (mck_i),
        .rst_i (rst_i),
        .d_i   (win_gate),
        .q_o   (gate_s)
    );

    mfm_edge_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i    (mck_i),
        .rst_i    (rst_i),
        .gate_s_i (gate_s),
        .result_o (main_result),
        .tog_o    (main_tog)
    );

    mfm_sync2 #(.W(1)) u_tog_sync (
        .clk_i (sclk_i),
        .rst_i (rst_i),
        .d_i   (main_tog),
        .q_o   (tog_s)
    );

    mfm_window_ctl #(.WIN(WIN), .TMO(TMO), .CNT_W(CNT_W)) u_window (
        .clk_i    (sclk_i),
        .rst_i    (rst_i),
        .start_i  (start_i),
        .tog_s_i  (tog_s),
        .result_i (main_result),
        .gate_o   (win_gate),
        .ready_o  (ready_o),
        .count_o  (count_o)
    );

    mfm_read_port #(.CNT_W(CNT_W), .RD_W(RD_W)) u_read (
        .clk_i     (sclk_i),
        .rst_i     (rst_i),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .ready_i   (ready_o),
        .count_i   (count_o),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/mfm_checker.sv
module mfm_checker #(
    parameter int WIN   = 16,
    parameter int TMO   = 8,
    parameter int CNT_W = 16
) (
    input logic             sclk_i,
    input logic             mck_i,
    input logic             rst_i,
    input logic             start_i,
    input logic             ready_o,
    input logic [CNT_W-1:0] count_o,
    input logic             win_gate,
    input logic             gate_s,
    input logic             main_tog
);
    logic [15:0] gate_run_q;
    logic        gate_prev_q;
    logic [15:0] wait_run_q;

    always_ff @(posedge sclk_i) begin
        if (rst_i) begin
            gate_run_q  <= '0;
            gate_prev_q <= 1'b0;
            wait_run_q  <= '0;
        end else begin
            gate_prev_q <= win_gate;
            if (win_gate && !gate_prev_q) begin
                gate_run_q <= 16'd1;
            end else if (win_gate) begin
                gate_run_q <= gate_run_q + 16'd1;
            end
            if (!win_gate && !ready_o) begin
                wait_run_q <= wait_run_q + 16'd1;
            end else begin
                wait_run_q <= '0;
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge sclk_i)
        rst_i |=> (!ready_o && count_o == '0));

    assert_gate_len_R2: assert property (@(posedge sclk_i) disable iff (rst_i)
        (gate_prev_q && !win_gate) |-> (gate_run_q == 16'(WIN)));

    assert_gate_bound_R2: assert property (@(posedge sclk_i) disable iff (rst_i)
        gate_run_q <= 16'(WIN));

    assert_ready_after_gate_R5: assert property (@(posedge sclk_i) disable iff (rst_i)
        $rose(ready_o) |-> !win_gate);

    assert_count_hold_R5: assert property (@(posedge sclk_i) disable iff (rst_i)
        (ready_o && !start_i) |=> (ready_o && $stable(count_o)));

    assert_timeout_bound_R6: assert property (@(posedge sclk_i) disable iff (rst_i)
        wait_run_q <= 16'(TMO + 2));

    assert_restart_clears_R7: assert property (@(posedge sclk_i) disable iff (rst_i)
        (start_i && ready_o) |=> !ready_o);

    assert_handoff_closed_R3: assert property (@(posedge mck_i) disable iff (rst_i)
        !$stable(main_tog) |-> !gate_s);
endmodule

bind mainclk_freq_meter mfm_checker #(.WIN(WIN), .TMO(TMO), .CNT_W(CNT_W)) u_chk (
    .sclk_i   (sclk_i),
    .mck_i    (mck_i),
    .rst_i    (rst_i),
    .start_i  (start_i),
    .ready_o  (ready_o),
    .count_o  (count_o),
    .win_gate (win_gate),
    .gate_s   (gate_s),
    .main_tog (main_tog)
);

// File: tb/test_mainclk_freq_meter.sv
`timescale 1ns/1ps
module test_mainclk_freq_meter;
    localparam int WIN   = 16;
    localparam int TMO   = 8;
    localparam int CNT_W = 10;
    localparam int RD_W  = 32;
    localparam int SATV  = (1 << CNT_W) - 1;

    logic             mck = 1'b0;
    logic             sclk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             rd_en = 1'b0;
    logic             rd_addr = 1'b0;
    logic [CNT_W-1:0] count;
    logic             ready;
    logic [RD_W-1:0]  rd_data;

    int  ratio = 10;
    bit  main_en = 1'b1;
    int  checks = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    mainclk_freq_meter #(.WIN(WIN), .TMO(TMO), .CNT_W(CNT_W), .RD_W(RD_W)) i_mainclk_freq_meter (
        .mck_i     (mck),
        .sclk_i    (sclk),
        .rst_i     (rst),
        .start_i   (start),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .count_o   (count),
        .ready_o   (ready),
        .rd_data_o (rd_data)
    );

    // 125 MHz main clock, can be stopped
    initial forever begin
        #4;
        if (main_en) mck = ~mck;
        else mck = 1'b0;
    end

    // slow clock: period 8*ratio ns, edges offset 2 ns from main edges
    initial begin
        #2;
        forever begin
            #(4 * ratio);
            sclk = ~sclk;
        end
    end

    function automatic int exp_count(input int r);
        int v;
        v = WIN * r;
        return (v > SATV) ? SATV : v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic slow_step(input int n);
        repeat (n) @(posedge sclk);
        #1;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        slow_step(1);
        start = 1'b0;
    endtask

    task automatic wait_ready(output int cyc);
        cyc = 0;
        while (!ready && cyc < 60) begin
            slow_step(1);
            cyc++;
        end
    endtask

    task automatic reg_read(input logic addr, output int val);
        rd_addr = addr;
        rd_en = 1'b1;
        slow_step(1);
        rd_en = 1'b0;
        val = int'(rd_data);
    endtask

    task automatic measure(input int r, input string tag);
        int cyc;
        int e;
        int c;
        ratio = r;
        slow_step(3);
        pulse_start();
        chk(ready == 1'b0, {tag, " R7 ready cleared by restart"}, int'(ready), 0);
        wait_ready(cyc);
        e = exp_count(r);
        c = int'(count);
        chk(ready == 1'b1 && cyc >= 16 && cyc <= 21, {tag, " R5 ready latency"}, cyc, 18);
        if (e == SATV) chk(c == SATV, {tag, " R4 saturated count"}, c, e);
        else chk(c >= e - 1 && c <= e + 1, {tag, " R3 count"}, c, e);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cyc;
        int v;
        int c0;
        int seed;
        seed = $urandom(32'd4711);
        rst = 1'b1;
        slow_step(3);
        chk(ready == 1'b0, "R1 ready in reset", int'(ready), 0);
        chk(count == '0, "R1 count in reset", int'(count), 0);
        rst = 1'b0;
        slow_step(1);
        chk(ready == 1'b0 && count == '0, "R1 outputs after release", int'(ready), 0);
        chk(rd_data == '0, "R1 read data after reset", int'(rd_data), 0);

        // R2: automatic first window after reset
        wait_ready(cyc);
        chk(ready == 1'b1 && cyc >= 16 && cyc <= 21, "R2 auto window latency", cyc, 18);
        v = int'(count);
        chk(v >= WIN * 10 - 1 && v <= WIN * 10 + 1, "R2 auto window count", v, WIN * 10);

        // R8: read port
        reg_read(1'b0, v);
        chk(v == 1, "R8 status read", v, 1);
        reg_read(1'b1, v);
        chk(v == int'(count), "R8 count read", v, int'(count));
        c0 = v;
        rd_addr = 1'b0;
        slow_step(3);
        chk(int'(rd_data) == c0, "R8 data holds without rd_en", int'(rd_data), c0);

        // R5: count holds while ready set
        c0 = int'(count);
        slow_step(25);
        chk(ready == 1'b1 && int'(count) == c0, "R5 count stable while ready", int'(count), c0);

        // directed and random ratios
        measure(5, "min ratio");
        measure(40, "max ratio");
        for (int i = 0; i < 8; i++) begin
            measure(5 + int'($urandom % 36), "random");
        end
        measure(SATV / WIN, "below sat");
        measure(81, "saturation");

        // R7: restart mid-measurement is ignored
        ratio = 12;
        slow_step(3);
        pulse_start();
        slow_step(4);
        chk(ready == 1'b0, "R5 ready low during gate", int'(ready), 0);
        pulse_start();
        wait_ready(cyc);
        chk(ready == 1'b1 && cyc >= 11 && cyc <= 16, "R7 mid restart ignored latency", cyc, 13);
        v = int'(count);
        chk(v >= WIN * 12 - 1 && v <= WIN * 12 + 1, "R7 mid restart count", v, WIN * 12);
        reg_read(1'b0, v);
        chk(v == 1, "R8 status after ready", v, 1);

        // R6: main clock absent
        ratio = 10;
        main_en = 1'b0;
        slow_step(3);
        pulse_start();
        wait_ready(cyc);
        chk(ready == 1'b1 && cyc >= 20 && cyc <= 28, "R6 timeout latency", cyc, 23);
        chk(count == '0, "R6 zero on absent clock", int'(count), 0);
        reg_read(1'b1, v);
        chk(v == 0, "R6 zero via read port", v, 0);
        main_en = 1'b1;
        slow_step(4);
        measure(9, "R6 recovery");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule